// File: doc/BRIEF.md
# Two-Row Compare-and-Swap Priority Queue

This block stores up to 2N (key, value) pairs and continuously presents the value whose key is the smallest unsigned number held. Storage is organised as two rows of N cells, an upper row and a lower row. Each cell carries an occupied flag, a key and a value. The lower row stays in ascending key order. In every column the lower key is no larger than the upper key. Occupied cells sit packed at the left, and an occupied upper cell always has an occupied cell below it. Because of this arrangement the minimum always sits in lower cell 0.

Every accepted operation takes two clocks. In the first clock a row shifts: the upper row moves right for an insert, and the lower row moves left for a delete. In the second clock all columns evaluate in parallel and swap their upper and lower cells where needed. During that second clock `is_busy` is high, and any request that arrives then is discarded, not held. A requester therefore waits for `is_busy` to be low before it raises a request.

Top module: `twin_row_pqueue`

## Requirements
- R1: While `rst_n` is low and after it is released, every cell is empty and the outputs read `is_empty`=1, `is_full`=0, `is_busy`=0, `min_val`=0.
- R2: When the queue is idle, `min_val` equals the value stored with the smallest key. It reads 0 when the queue holds nothing.
- R3: `is_empty` is 1 exactly when no pair is stored. `is_full` is 1 exactly when 2N pairs are stored.
- R4: After a request is accepted at a clock edge, `is_busy` is 1 for exactly the next cycle and then returns to 0.
- R5: An insert is accepted only while idle and not full. An insert raised while full changes nothing and leaves `is_busy` at 0.
- R6: A delete is accepted only while idle and not empty, and it removes the pair with the smallest key. A delete raised while empty leaves `is_busy` at 0 and the queue empty.
- R7: When `ins_req` and `del_req` are both 1 while idle, only the insert is considered. If the queue is full, neither operation takes place.
- R8: A request present at a clock edge while `is_busy` is 1 is dropped and never takes effect later.
- R9: Keys are ordered as unsigned numbers, so a key with its top bit set ranks above every key with that bit clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ins_req | input | 1 | Insert request for one cycle |
| del_req | input | 1 | Delete-minimum request for one cycle |
| key_in | input | KW | Key of the pair to insert |
| val_in | input | VW | Value of the pair to insert |
| min_val | output | VW | Value paired with the smallest stored key, or 0 when empty |
| is_empty | output | 1 | No pair stored |
| is_full | output | 1 | All 2N cells occupied |
| is_busy | output | 1 | Compare-and-swap cycle in progress; requests are ignored |

## Verification
The ordering assertions assume that no two stored keys are equal, because with equal keys the pair chosen among them is not defined. The stimulus therefore draws each new key from values not currently in the queue, and it never uses key 0, so that key 0 can serve as a dropped-request probe. The assertions also assume that requests reach the block as clean synchronous pulses. The bench drives them only on falling edges and holds each one for a single cycle, with an optional second pulse placed deliberately inside the busy cycle.

// File: rtl/twin_row_pkg.sv
package twin_row_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_INSERT = 2'd1,
    PH_DELETE = 2'd2
  } pq_phase_e;

endpackage

// File: rtl/pq_phase_ctrl.sv
module pq_phase_ctrl
  import twin_row_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ins_req,
  input  logic del_req,
  input  logic top_last_occ,
  input  logic bot_first_occ,
  output logic do_ins,
  output logic do_del,
  output logic do_swap
);

  pq_phase_e phase_q;
  pq_phase_e phase_d;
  logic      idle;

  assign idle    = (phase_q == PH_IDLE);
  // insert has precedence: a raised insert blocks delete even when refused
  assign do_ins  = idle && ins_req && !top_last_occ;
  assign do_del  = idle && !ins_req && del_req && bot_first_occ;
  assign do_swap = !idle;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE: begin
        if (do_ins)      phase_d = PH_INSERT;
        else if (do_del) phase_d = PH_DELETE;
      end
      PH_INSERT: phase_d = PH_IDLE;
      PH_DELETE: phase_d = PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

endmodule

// File: rtl/pq_swap_cell.sv
module pq_swap_cell #(
  parameter int KW = 8
) (
  input  logic          top_occ,
  input  logic          bot_occ,
  input  logic [KW-1:0] top_key,
  input  logic [KW-1:0] bot_key,
  output logic          swap
);

  logic top_smaller;

  assign top_smaller = (top_key < bot_key);
  assign swap        = top_occ && (!bot_occ || top_smaller);

endmodule

// File: rtl/pq_row_store.sv
module pq_row_store #(
  parameter int N  = 4,
  parameter int KW = 8,
  parameter int VW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  do_ins,
  input  logic                  do_del,
  input  logic                  do_swap,
  input  logic [N-1:0]          swap_col,
  input  logic [KW-1:0]         key_in,
  input  logic [VW-1:0]         val_in,
  output logic [N-1:0]          top_occ,
  output logic [N-1:0]          bot_occ,
  output logic [N-1:0][KW-1:0]  top_key,
  output logic [N-1:0][KW-1:0]  bot_key,
  output logic [N-1:0][VW-1:0]  top_val,
  output logic [N-1:0][VW-1:0]  bot_val
);

  localparam int LAST = N - 1;

  logic [N-1:0]         top_occ_d, bot_occ_d;
  logic [N-1:0][KW-1:0] top_key_d, bot_key_d;
  logic [N-1:0][VW-1:0] top_val_d, bot_val_d;
  logic                 upd_en;

  assign upd_en = do_ins || do_del || do_swap;

  always_comb begin
    top_occ_d = top_occ;
    bot_occ_d = bot_occ;
    top_key_d = top_key;
    bot_key_d = bot_key;
    top_val_d = top_val;
    bot_val_d = bot_val;
    if (do_ins) begin
      for (int i = 1; i < N; i++) begin
        top_occ_d[i] = top_occ[i-1];
        top_key_d[i] = top_key[i-1];
        top_val_d[i] = top_val[i-1];
      end
      top_occ_d[0] = 1'b1;
      top_key_d[0] = key_in;
      top_val_d[0] = val_in;
    end else if (do_del) begin
      for (int i = 0; i < LAST; i++) begin
        bot_occ_d[i] = bot_occ[i+1];
        bot_key_d[i] = bot_key[i+1];
        bot_val_d[i] = bot_val[i+1];
      end
      bot_occ_d[LAST] = 1'b0;
    end else if (do_swap) begin
      for (int i = 0; i < N; i++) begin
        if (swap_col[i]) begin
          top_occ_d[i] = bot_occ[i];
          top_key_d[i] = bot_key[i];
          top_val_d[i] = bot_val[i];
          bot_occ_d[i] = top_occ[i];
          bot_key_d[i] = top_key[i];
          bot_val_d[i] = top_val[i];
        end
      end
    end
  end

  // occupancy flags carry the reset; payload registers need none
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_occ <= '0;
      bot_occ <= '0;
    end else if (upd_en) begin
      top_occ <= top_occ_d;
      bot_occ <= bot_occ_d;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_en) begin
      top_key <= top_key_d;
      bot_key <= bot_key_d;
      top_val <= top_val_d;
      bot_val <= bot_val_d;
    end
  end

endmodule

// File: rtl/twin_row_pqueue.sv
module twin_row_pqueue #(
  parameter int N  = 4,
  parameter int KW = 8,
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_req,
  input  logic          del_req,
  input  logic [KW-1:0] key_in,
  input  logic [VW-1:0] val_in,
  output logic [VW-1:0] min_val,
  output logic          is_empty,
  output logic          is_full,
  output logic          is_busy
);

  localparam int LAST = N - 1;

  logic                 do_ins, do_del, do_swap;
  logic [N-1:0]         swap_col;
  logic [N-1:0]         top_occ, bot_occ;
  logic [N-1:0][KW-1:0] top_key, bot_key;
  logic [N-1:0][VW-1:0] top_val, bot_val;

  pq_phase_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .ins_req       (ins_req),
    .del_req       (del_req),
    .top_last_occ  (top_occ[LAST]),
    .bot_first_occ (bot_occ[0]),
    .do_ins        (do_ins),
    .do_del        (do_del),
    .do_swap       (do_swap)
  );

  for (genvar c = 0; c < N; c++) begin : g_col
    pq_swap_cell #(.KW(KW)) u_cell (
      .top_occ (top_occ[c]),
      .bot_occ (bot_occ[c]),
      .top_key (top_key[c]),
      .bot_key (bot_key[c]),
      .swap    (swap_col[c])
    );
  end

  pq_row_store #(.N(N), .KW(KW), .VW(VW)) u_rows (
    .clk      (clk),
    .rst_n    (rst_n),
    .do_ins   (do_ins),
    .do_del   (do_del),
    .do_swap  (do_swap),
    .swap_col (swap_col),
    .key_in   (key_in),
    .val_in   (val_in),
    .top_occ  (top_occ),
    .bot_occ  (bot_occ),
    .top_key  (top_key),
    .bot_key  (bot_key),
    .top_val  (top_val),
    .bot_val  (bot_val)
  );

  assign min_val  = bot_occ[0] ? bot_val[0] : '0;
  assign is_empty = !bot_occ[0];
  assign is_full  = top_occ[LAST];
  assign is_busy  = do_swap;

endmodule

// File: rtl/pq_checker.sv
module pq_checker #(
  parameter int N  = 4,
  parameter int VW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ins_req,
  input logic          del_req,
  input logic [VW-1:0] min_val,
  input logic          is_empty,
  input logic          is_full,
  input logic          is_busy,
  input logic [N-1:0]  top_occ,
  input logic [N-1:0]  bot_occ
);

  AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    is_busy |=> !is_busy); // R4

  AST_INSERT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_busy && ins_req && !is_full) |=> is_busy); // R5

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_busy && ins_req && is_full) |=> (!is_busy && is_full && $stable(min_val))); // R7

  AST_EMPTY_DELETE: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_busy && !ins_req && del_req && is_empty) |=> (!is_busy && is_empty)); // R6

  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    is_empty |-> (min_val == '0)); // R2

  AST_NOT_BOTH_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_empty && is_full)); // R3

  AST_LOWER_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
    !is_busy |-> ((bot_occ & (bot_occ + 1'b1)) == '0)); // R3

  AST_UPPER_SUPPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    !is_busy |-> ((top_occ & ~bot_occ) == '0)); // R3

endmodule

bind twin_row_pqueue pq_checker #(.N(N), .VW(VW)) u_pq_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ins_req  (ins_req),
  .del_req  (del_req),
  .min_val  (min_val),
  .is_empty (is_empty),
  .is_full  (is_full),
  .is_busy  (is_busy),
  .top_occ  (top_occ),
  .bot_occ  (bot_occ)
);

// File: tb/tb_twin_row_pqueue.sv
`timescale 1ns/1ps
module tb_twin_row_pqueue;

  localparam int N   = 4;
  localparam int KW  = 8;
  localparam int VW  = 8;
  localparam int CAP = 2 * N;

  logic          clk;
  logic          rst_n;
  logic          ins_req, del_req;
  logic [KW-1:0] key_in;
  logic [VW-1:0] val_in;
  logic [VW-1:0] min_val;
  logic          is_empty, is_full, is_busy;

  int n_tests;
  int n_fail;
  int cnt;
  logic [KW-1:0] mk [CAP];
  logic [VW-1:0] mv [CAP];

  twin_row_pqueue #(.N(N), .KW(KW), .VW(VW)) dut (
    .clk(clk), .rst_n(rst_n), .ins_req(ins_req), .del_req(del_req),
    .key_in(key_in), .val_in(val_in), .min_val(min_val),
    .is_empty(is_empty), .is_full(is_full), .is_busy(is_busy)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] val_of(input logic [KW-1:0] k);
    return k ^ 8'h5A;
  endfunction

  function automatic int min_idx();
    int m = 0;
    for (int i = 1; i < cnt; i++) if (mk[i] < mk[m]) m = i;
    return m;
  endfunction

  function automatic logic [VW-1:0] exp_min();
    if (cnt == 0) return '0;
    return mv[min_idx()];
  endfunction

  function automatic bit has_key(input logic [KW-1:0] k);
    for (int i = 0; i < cnt; i++) if (mk[i] == k) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [KW-1:0] fresh_key();
    logic [KW-1:0] k;
    do k = KW'($urandom_range(1, 255)); while (has_key(k));
    return k;
  endfunction

  // one request pulse; optional probe pulse placed in the busy cycle (R8)
  task automatic run_op(input string tag, input bit ins, input bit del,
                        input logic [KW-1:0] k, input bit poke);
    bit acc_ins, acc_del;
    int m;
    acc_ins = ins && (cnt < CAP);
    acc_del = !ins && del && (cnt > 0);
    @(negedge clk);
    ins_req = ins; del_req = del; key_in = k; val_in = val_of(k);
    @(negedge clk);
    ins_req = 1'b0; del_req = 1'b0;
    if (acc_ins || acc_del) begin
      check({tag, " R4 busy set"}, is_busy, 1);
      if (poke) begin
        ins_req = 1'b1; del_req = 1'b1; key_in = '0; val_in = 8'hEE;
      end
      @(negedge clk);
      ins_req = 1'b0; del_req = 1'b0;
      check({tag, " R4 busy clear"}, is_busy, 0);
    end else begin
      check({tag, " R5 R6 R7 not accepted"}, is_busy, 0);
    end
    if (acc_ins) begin
      mk[cnt] = k; mv[cnt] = val_of(k); cnt++;
    end else if (acc_del) begin
      m = min_idx();
      mk[m] = mk[cnt-1]; mv[m] = mv[cnt-1]; cnt--;
    end
    check({tag, " R2 min"},   min_val,  exp_min());
    check({tag, " R3 empty"}, is_empty, (cnt == 0));
    check({tag, " R3 full"},  is_full,  (cnt == CAP));
  endtask

  initial begin
    n_tests = 0; n_fail = 0; cnt = 0;
    ins_req = 0; del_req = 0; key_in = '0; val_in = '0;
    rst_n = 1'b0;
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    check("R1 empty in reset", is_empty, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 empty", is_empty, 1);
    check("R1 full",  is_full,  0);
    check("R1 busy",  is_busy,  0);
    check("R1 value", min_val,  0);

    run_op("R6 delete on empty", 0, 1, 8'h00, 0);
    run_op("R9 low key", 1, 0, 8'h05, 0);
    run_op("R9 high key", 1, 0, 8'hF0, 0);
    check("R9 unsigned order", min_val, val_of(8'h05));

    for (int i = 0; i < CAP - 2; i++) run_op("R5 fill", 1, 0, 8'hE0 - 8'(i * 16), 0);
    check("R3 full after fill", is_full, 1);
    run_op("R5 insert while full", 1, 0, 8'h01, 0);
    run_op("R7 both while full", 1, 1, 8'h02, 0);
    check("R7 still full", is_full, 1);
    run_op("R6 delete min", 0, 1, 8'h00, 0);
    run_op("R7 insert wins", 1, 1, 8'h03, 0);
    check("R7 new min", min_val, val_of(8'h03));
    run_op("R8 probe during busy", 0, 1, 8'h00, 1);
    check("R8 probe dropped", min_val, exp_min());
    while (cnt > 0) run_op("R6 drain", 0, 1, 8'h00, 0);
    check("R6 drained", is_empty, 1);

    for (int t = 0; t < 400; t++) begin
      bit ins, del;
      ins = ($urandom_range(0, 99) < 55);
      del = ($urandom_range(0, 99) < 60);
      run_op("random", ins, del, fresh_key(), ($urandom_range(0, 4) == 0));
    end
    while (cnt > 0) run_op("R6 final drain", 0, 1, 8'h00, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule